// File: doc/BRIEF.md
# Event-Triggered Audio DMA Channel Sequencer

This block is the control engine of one audio DMA channel. Software programs a source address, a destination address and a block count through a small register port, then arms the channel together with an event number. The channel waits until the chosen hardware trigger line fires. It then checks that the source and destination targets form a supported pair, and moves the data as a run of 128-byte blocks. Each block is one request/acknowledge exchange with an external data mover. A final notifier write closes the transfer.

A three-bit status code reports the channel's progress through its phases. A one-cycle completion pulse feeds the interrupt logic. A global clear input abandons a transfer that is waiting or running. It still produces the completion pulse, so software sees the cancelled transfer end as if it had finished. The data path itself is not part of the block.

Top module: `audio_dma_seq`

## Requirements
- R1: After reset the status code is 0 (done), the request bit (bit 0 of the control word, `reg_sel`=0) reads 0, and `blk_req`, `ntf_req` and `done_pulse` are low.
- R2: Writing the control word with bit 0 set while the channel is idle latches the event number from bits 20:16 and moves the status (control word bits 26:24 and `status`) to 1, waiting for the event. While the channel is busy (status 1 to 4) the request bit reads 1.
- R3: Event number 0 fires at once. Any other number n fires only when `events[n]` is high, and activity on other lines is ignored. On the firing edge the status becomes 2 (pending) for one cycle.
- R4: From pending, the transfer starts (status 3) only if the source target (bits 1:0 of `reg_sel`=1) is 2 and the destination target (bits 1:0 of `reg_sel`=2) is 1. Otherwise the status becomes 6 (error), no block request is issued and no completion pulse is raised.
- R5: A transfer issues size+1 block requests, where size is bits 6:0 of `reg_sel`=3. Block k carries addresses start+k*128, with bits 6:0 zero. Address bits 6:2 read back 0.
- R6: After the last block is acknowledged, the status becomes 4 (notify) and `ntf_req` is held until `ntf_ack`. The channel then returns to status 0 with the request bit clear.
- R7: `done_pulse` is high for exactly one cycle, in the cycle after the channel leaves notify.
- R8: A high `clear` while the channel is busy moves it to status 5, drops `blk_req` and `ntf_req`, and raises `done_pulse` once. A clear while the channel is idle has no effect.
- R9: Register writes while the channel is busy are ignored. This covers the source, destination, size and control words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 2 | register select: 0 control, 1 source, 2 destination, 3 size |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data of the selected register |
| events | input | 32 | hardware trigger lines, indexed by event number |
| clear | input | 1 | global cancel |
| blk_req | output | 1 | block transfer request |
| blk_src_addr | output | 32 | source address of the current block |
| blk_dst_addr | output | 32 | destination address of the current block |
| blk_ack | input | 1 | block transfer finished |
| ntf_req | output | 1 | notifier write request |
| ntf_ack | input | 1 | notifier write finished |
| done_pulse | output | 1 | one-cycle completion pulse |
| status | output | 3 | phase code |

## Verification
The assertions check the following on every cycle: a kick arms the channel, a bad target pair leads straight to error without a block request, consecutive block addresses step by 128, busy-time writes leave the registers unchanged, a clear on a busy channel leads to the clear state with a pulse, and the completion pulse lasts one cycle and only lands in an idle state. Only the bench scenarios can show the rest. These are the exact number of blocks for several sizes (including the largest), that an unselected event line leaves the channel waiting, that notify holds for as long as the acknowledge is withheld, and that a clear on an idle channel does nothing.

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 7,
  parameter int BLK_LG = 7,
  parameter int NEVT   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [NEVT-1:0]   events,
  input  logic              clear,
  output logic              blk_req,
  output logic [ADDR_W-1:0] blk_src_addr,
  output logic [ADDR_W-1:0] blk_dst_addr,
  input  logic              blk_ack,
  output logic              ntf_req,
  input  logic              ntf_ack,
  output logic              done_pulse,
  output logic [2:0]        status
);
  localparam int EVT_W   = $clog2(NEVT);
  localparam int START_W = ADDR_W - BLK_LG;

  typedef enum logic [2:0] {
    S_DONE = 3'd0, S_EVENT = 3'd1, S_PEND = 3'd2, S_DMA = 3'd3,
    S_NTFY = 3'd4, S_CLR = 3'd5, S_ERR = 3'd6
  } st_t;

  st_t                st;
  logic [EVT_W-1:0]   evsel;
  logic [START_W-1:0] src_start, dst_start;
  logic [1:0]         src_tgt, dst_tgt;
  logic [SIZE_W-1:0]  size_q, cnt;

  logic busy, wr_ok, kick, fire, tgt_ok, last;
  logic unused_wbits;

  assign busy   = (st == S_EVENT) || (st == S_PEND) || (st == S_DMA) || (st == S_NTFY);
  assign wr_ok  = reg_we && !busy;
  assign kick   = wr_ok && (reg_sel == 2'd0) && reg_wdata[0];
  assign fire   = (evsel == '0) || events[evsel];
  assign tgt_ok = (src_tgt == 2'd2) && (dst_tgt == 2'd1);
  assign last   = (cnt == size_q);
  assign unused_wbits = ^reg_wdata;

  assign status       = st;
  assign blk_req      = (st == S_DMA);
  assign ntf_req      = (st == S_NTFY);
  assign blk_src_addr = {src_start + START_W'(cnt), {BLK_LG{1'b0}}};
  assign blk_dst_addr = {dst_start + START_W'(cnt), {BLK_LG{1'b0}}};

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: begin
        reg_rdata[26:24]       = st;
        reg_rdata[16 +: EVT_W] = evsel;
        reg_rdata[0]           = busy;
      end
      2'd1: begin
        reg_rdata[ADDR_W-1:BLK_LG] = src_start;
        reg_rdata[1:0]             = src_tgt;
      end
      2'd2: begin
        reg_rdata[ADDR_W-1:BLK_LG] = dst_start;
        reg_rdata[1:0]             = dst_tgt;
      end
      default: reg_rdata[SIZE_W-1:0] = size_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_DONE;
      evsel      <= '0;
      src_start  <= '0;
      dst_start  <= '0;
      src_tgt    <= '0;
      dst_tgt    <= '0;
      size_q     <= '0;
      cnt        <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (wr_ok) begin
        case (reg_sel)
          2'd0: if (reg_wdata[0]) evsel <= reg_wdata[16 +: EVT_W];
          2'd1: begin src_start <= reg_wdata[ADDR_W-1:BLK_LG]; src_tgt <= reg_wdata[1:0]; end
          2'd2: begin dst_start <= reg_wdata[ADDR_W-1:BLK_LG]; dst_tgt <= reg_wdata[1:0]; end
          default: size_q <= reg_wdata[SIZE_W-1:0];
        endcase
      end
      if (clear && busy) begin
        st         <= S_CLR;
        done_pulse <= 1'b1;
      end else begin
        case (st)
          S_EVENT: if (fire) st <= S_PEND;
          S_PEND: begin
            cnt <= '0;
            st  <= tgt_ok ? S_DMA : S_ERR;
          end
          S_DMA: if (blk_ack) begin
            if (last) st <= S_NTFY;
            else      cnt <= cnt + 1'b1;
          end
          S_NTFY: if (ntf_ack) begin
            st         <= S_DONE;
            done_pulse <= 1'b1;
          end
          default: if (kick) st <= S_EVENT;
        endcase
      end
    end
  end

  // R2
  arm_on_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (status == 3'd1));

  // R4
  bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && !tgt_ok && !clear) |=> (status == 3'd6 && !blk_req));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && blk_ack && !last && !clear) |=>
      (blk_src_addr == $past(blk_src_addr) + (ADDR_W'(1) << BLK_LG)) &&
      (blk_dst_addr == $past(blk_dst_addr) + (ADDR_W'(1) << BLK_LG)));

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R7
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (status == 3'd0 || status == 3'd5));

  // R8
  clear_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && busy) |=> (status == 3'd5 && done_pulse && !blk_req && !ntf_req));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(src_start) && $stable(dst_start) && $stable(size_q) &&
                          $stable(src_tgt) && $stable(dst_tgt) && $stable(evsel)));
endmodule

// File: tb/test_audio_dma_seq.sv
`timescale 1ns/1ps
module test_audio_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] events = '0;
  logic        clear = 1'b0;
  logic        blk_req;
  logic [31:0] blk_src_addr, blk_dst_addr;
  logic        blk_ack = 1'b0;
  logic        ntf_req;
  logic        ntf_ack = 1'b0;
  logic        done_pulse;
  logic [2:0]  status;

  audio_dma_seq i_audio_dma_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .clear(clear),
    .blk_req(blk_req), .blk_src_addr(blk_src_addr), .blk_dst_addr(blk_dst_addr),
    .blk_ack(blk_ack), .ntf_req(ntf_req), .ntf_ack(ntf_ack),
    .done_pulse(done_pulse), .status(status)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int pulses = 0, blk_seen = 0;
  bit resp_en = 1'b1, ntf_en = 1'b1, finished = 1'b0;
  logic [31:0] exp_src[$], exp_dst[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor: acknowledges blocks and scores their addresses
  always @(negedge clk) begin
    logic nack;
    logic [31:0] es, ed;
    nack = blk_req && resp_en && !blk_ack;
    blk_ack = nack;
    ntf_ack = ntf_req && ntf_en;
    if (done_pulse) pulses++;
    if (nack) begin
      blk_seen++;
      if (exp_src.size() == 0) chk(1'b0, "R5 unexpected block", blk_src_addr, 32'h0);
      else begin
        es = exp_src.pop_front();
        ed = exp_dst.pop_front();
        chk(blk_src_addr == es, "R5 source address", blk_src_addr, es);
        chk(blk_dst_addr == ed, "R5 destination address", blk_dst_addr, ed);
      end
    end
  end

  task automatic push_blocks(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      exp_src.push_back(s + 32'(k) * 32'd128);
      exp_dst.push_back(d + 32'(k) * 32'd128);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wait_status(input logic [2:0] code, input int lim);
    for (int i = 0; i < lim && status != code; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p0, b0;
    idle(2);
    rd(2'd0, v);
    chk(v[26:24] == 3'd0 && v[0] == 1'b0, "R1 reset control", v, 32'h0);
    chk(!blk_req && !ntf_req && !done_pulse, "R1 reset outputs", {blk_req, ntf_req, done_pulse}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // three blocks, event 5, notify held back
    wr(2'd1, 32'h1000_0042);
    wr(2'd2, 32'h2000_0081);
    wr(2'd3, 32'd2);
    rd(2'd1, v);
    chk(v == 32'h1000_0002, "R5 address low bits", v, 32'h1000_0002);
    ntf_en = 1'b0;
    wr(2'd0, (32'd5 << 16) | 32'd1);
    rd(2'd0, v);
    chk(v[26:24] == 3'd1 && v[0] && v[20:16] == 5'd5, "R2 armed", v, 32'h0105_0001);
    wr(2'd1, 32'hFFFF_FF82);
    wr(2'd3, 32'd9);
    wr(2'd0, (32'd7 << 16) | 32'd1);
    rd(2'd1, v);
    chk(v == 32'h1000_0002, "R9 source kept", v, 32'h1000_0002);
    rd(2'd3, v);
    chk(v == 32'd2, "R9 size kept", v, 32'd2);
    rd(2'd0, v);
    chk(v[20:16] == 5'd5, "R9 event kept", {27'd0, v[20:16]}, 32'd5);
    chk(status == 3'd1, "R3 still waiting", {29'd0, status}, 32'd1);
    push_blocks(32'h1000_0000, 32'h2000_0080, 3);
    b0 = blk_seen;
    events[5] = 1'b1;
    @(negedge clk);
    events[5] = 1'b0;
    chk(status == 3'd2, "R3 pending", {29'd0, status}, 32'd2);
    wait_status(3'd4, 100);
    chk(blk_seen - b0 == 3, "R5 block count 3", 32'(blk_seen - b0), 32'd3);
    idle(3);
    chk(status == 3'd4 && ntf_req, "R6 notify held", {28'd0, ntf_req, status}, 32'hC);
    p0 = pulses;
    ntf_en = 1'b1;
    wait_status(3'd0, 20);
    idle(3);
    chk(pulses - p0 == 1, "R7 one pulse", 32'(pulses - p0), 32'd1);
    rd(2'd0, v);
    chk(v[26:24] == 3'd0 && !v[0], "R6 back to done", v, 32'h0);

    // event on a channel-completion line, other lines ignored
    wr(2'd3, 32'd0);
    wr(2'd0, (32'h14 << 16) | 32'd1);
    events[3] = 1'b1; events[5] = 1'b1;
    idle(3);
    events = '0;
    chk(status == 3'd1, "R3 wrong line ignored", {29'd0, status}, 32'd1);
    push_blocks(32'h1000_0000, 32'h2000_0080, 1);
    b0 = blk_seen;
    events[20] = 1'b1;
    @(negedge clk);
    events[20] = 1'b0;
    wait_status(3'd0, 50);
    idle(2);
    chk(blk_seen - b0 == 1, "R5 single block", 32'(blk_seen - b0), 32'd1);

    // bad target pair
    wr(2'd1, 32'h1000_0001);
    p0 = pulses; b0 = blk_seen;
    wr(2'd0, 32'd1);
    idle(5);
    rd(2'd0, v);
    chk(v[26:24] == 3'd6 && !v[0], "R4 error status", v, 32'h0600_0000);
    chk(blk_seen == b0 && pulses == p0, "R4 no block no pulse", 32'(blk_seen - b0 + pulses - p0), 32'd0);

    // largest size, starting from the error state
    wr(2'd1, 32'h3000_0002);
    wr(2'd3, 32'd127);
    push_blocks(32'h3000_0000, 32'h2000_0080, 128);
    b0 = blk_seen;
    wr(2'd0, 32'd1);
    wait_status(3'd0, 1000);
    idle(2);
    chk(blk_seen - b0 == 128, "R5 block count 128", 32'(blk_seen - b0), 32'd128);

    // clear during transfer
    resp_en = 1'b0;
    wr(2'd3, 32'd5);
    wr(2'd0, 32'd1);
    wait_status(3'd3, 20);
    chk(blk_req, "R4 transfer started", {31'd0, blk_req}, 32'd1);
    p0 = pulses;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(status == 3'd5 && !blk_req, "R8 cleared", {28'd0, blk_req, status}, 32'd5);
    idle(2);
    chk(pulses - p0 == 1, "R8 pulse on clear", 32'(pulses - p0), 32'd1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    idle(2);
    chk(status == 3'd5 && pulses - p0 == 1, "R8 idle clear ignored", {29'd0, status}, 32'd5);

    // clear while waiting for an event
    wr(2'd0, (32'd9 << 16) | 32'd1);
    chk(status == 3'd1, "R2 armed again", {29'd0, status}, 32'd1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(status == 3'd5, "R8 clear while waiting", {29'd0, status}, 32'd5);
    resp_en = 1'b1;
    idle(3);
    chk(exp_src.size() == 0, "R5 scoreboard drained", 32'(exp_src.size()), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule